// File: doc/BRIEF.md
# Binary Talk-Mode Port Sampler

This block serves a raw-binary read stream over five byte-wide input ports. While its talk enable is high it raises an inhibit output for a fixed number of cycles so that external logic can freeze its data. On the last inhibit cycle it captures all ports into a shadow register. It then drops inhibit and offers the captured bytes one at a time on a ready/valid byte interface, highest-numbered port first. The fifth byte carries an end-of-message flag. No terminator bytes are sent.

Once the end-of-message byte is accepted, the block at once starts a new inhibit window and re-captures the ports. The next message is then ready without toggling talk enable. Over N complete messages the inhibit output therefore pulses N+1 times. Dropping talk enable at any point abandons the current message. The next enable starts again with a fresh capture and the first byte.

Top module: `bin_talk_sampler`

## Requirements
- R1: Out of reset, and while talk_en_i is low, inhibit_o and valid_o are 0. When talk_en_i is sampled high in the idle state, inhibit_o rises on the next cycle. valid_o is never 1 while inhibit_o is 1.
- R2: Each inhibit pulse lasts exactly INH_CYCLES clock cycles.
- R3: The shadow register loads port_i as it stands in the last cycle of an inhibit pulse. Port changes after that do not alter the bytes of the message.
- R4: Port k (k = 1..5) sits at port_i[8k-1:8(k-1)]. Bytes leave in the order port 5, port 4, port 3, port 2, port 1.
- R5: last_o is 1 with the fifth byte of a message and 0 with the other four.
- R6: The cycle after the fifth byte is accepted with talk_en_i still high, inhibit_o is 1 and a new capture begins. N complete messages give N+1 inhibit pulses.
- R7: When talk_en_i drops, inhibit_o and valid_o are 0 on the next cycle. The next enable restarts with an inhibit pulse and the port-5 byte.
- R8: While valid_o is 1 and ready_i is 0, data_o, last_o and valid_o hold.
- R9: Each message has exactly five bytes. valid_o stays 0 from the acceptance of the fifth byte until the next capture is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| talk_en_i | input | 1 | Starts (high) and stops (low) the read stream |
| port_i | input | 40 | Five input ports, port 1 in the low byte |
| inhibit_o | output | 1 | High while the ports are being captured |
| data_o | output | 8 | Current output byte |
| valid_o | output | 1 | data_o is offered |
| last_o | output | 1 | Current byte ends the message |
| ready_i | input | 1 | Sink accepts the byte this cycle |

## Verification
The bench changes the ports during the inhibit window and again after it ends. A design that captured too early, or read the live ports while sending, would emit the wrong bytes. It streams three messages back to back and counts inhibit pulses, so a missing re-capture or a spurious extra pulse shows up as a wrong count. It stalls the sink in mid-message, which exposes a byte index that advances without a handshake. It also drops talk enable after two bytes: a design that kept its byte index would restart at the wrong port, and one that kept valid high would leak a byte.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INH  = 2'd1,
    ST_SEND = 2'd2
  } bts_state_e;
endpackage

// File: rtl/bts_inhibit_timer.sv
module bts_inhibit_timer #(
  parameter int unsigned INH_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (INH_CYCLES > 1) ? $clog2(INH_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(INH_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || done_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/bts_shadow_mux.sv
module bts_shadow_mux #(
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned PORT_W    = 8,
  localparam int unsigned IW       = $clog2(NUM_PORTS),
  localparam int unsigned TW       = NUM_PORTS * PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TW-1:0]     port_i,
  input  logic [IW-1:0]     idx_i,
  output logic [PORT_W-1:0] byte_o
);
  logic [TW-1:0]     shadow_q;
  logic [PORT_W-1:0] ordered [NUM_PORTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (load_i) shadow_q <= port_i;
  end

  // slot 0 carries the highest-numbered port
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_order
    assign ordered[g] = shadow_q[(NUM_PORTS-1-g)*PORT_W +: PORT_W];
  end

  assign byte_o = ordered[idx_i];
endmodule

// File: rtl/bin_talk_sampler.sv
module bin_talk_sampler
  import bts_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 5,
  parameter int unsigned PORT_W     = 8,
  parameter int unsigned INH_CYCLES = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        talk_en_i,
  input  logic [NUM_PORTS*PORT_W-1:0] port_i,
  output logic                        inhibit_o,
  output logic [PORT_W-1:0]           data_o,
  output logic                        valid_o,
  output logic                        last_o,
  input  logic                        ready_i
);
  localparam int unsigned IW = $clog2(NUM_PORTS);
  localparam logic [IW-1:0] IDX_LAST = IW'(NUM_PORTS - 1);

  bts_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          inh_done, load, fire;

  bts_inhibit_timer #(.INH_CYCLES(INH_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_INH && talk_en_i),
    .done_o(inh_done)
  );

  assign load = (state_q == ST_INH) && talk_en_i && inh_done;
  assign fire = valid_o && ready_i;

  bts_shadow_mux #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_shadow (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .port_i(port_i),
    .idx_i (idx_q),
    .byte_o(data_o)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (!talk_en_i) begin
      state_d = ST_IDLE;
      idx_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_INH;
        ST_INH: if (inh_done) begin
          state_d = ST_SEND;
          idx_d   = '0;
        end
        ST_SEND: if (fire) begin
          if (idx_q == IDX_LAST) begin
            state_d = ST_INH;   // pre-read for the next message
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign inhibit_o = (state_q == ST_INH);
  assign valid_o   = (state_q == ST_SEND);
  assign last_o    = valid_o && (idx_q == IDX_LAST);
endmodule

// File: rtl/bts_checker.sv
module bts_checker #(
  parameter int unsigned NUM_PORTS  = 5,
  parameter int unsigned PORT_W     = 8,
  parameter int unsigned INH_CYCLES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              talk_en_i,
  input logic              inhibit_o,
  input logic [PORT_W-1:0] data_o,
  input logic              valid_o,
  input logic              last_o,
  input logic              ready_i
);
  logic [7:0]  beat_q;
  logic [15:0] inh_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_q <= '0;
    else if (!talk_en_i) beat_q <= '0;
    else if (valid_o && ready_i) beat_q <= last_o ? 8'd0 : beat_q + 8'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        inh_len_q <= '0;
    else if (inhibit_o) inh_len_q <= inh_len_q + 16'd1;
    else                inh_len_q <= '0;
  end

  AST_INH_EXCLUDES_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_o |-> !valid_o); // R1
  AST_INH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_o |-> (inh_len_q < 16'(INH_CYCLES))); // R2
  AST_LAST_ON_FIFTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (last_o == (beat_q == 8'(NUM_PORTS - 1)))); // R5
  AST_REREAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && last_o && talk_en_i) |=> inhibit_o); // R6
  AST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !talk_en_i |=> (!inhibit_o && !valid_o)); // R7
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && talk_en_i) |=> (valid_o && $stable(data_o) && $stable(last_o))); // R8
endmodule

bind bin_talk_sampler bts_checker #(
  .NUM_PORTS (NUM_PORTS),
  .PORT_W    (PORT_W),
  .INH_CYCLES(INH_CYCLES)
) u_bts_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .talk_en_i(talk_en_i),
  .inhibit_o(inhibit_o),
  .data_o   (data_o),
  .valid_o  (valid_o),
  .last_o   (last_o),
  .ready_i  (ready_i)
);

// File: tb/bin_talk_sampler_tb_top.sv
module bin_talk_sampler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int INH        = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        talk_en = 1'b0;
  logic [39:0] ports = '0;
  logic        inhibit, valid, last, ready = 1'b0;
  logic [7:0]  data;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  logic inh_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bin_talk_sampler #(.NUM_PORTS(5), .PORT_W(8), .INH_CYCLES(INH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .talk_en_i(talk_en), .port_i(ports),
    .inhibit_o(inhibit), .data_o(data), .valid_o(valid), .last_o(last),
    .ready_i(ready)
  );

  always @(negedge clk) begin
    if (inhibit && !inh_prev) pulses++;
    inh_prev = inhibit;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] port_byte(input logic [39:0] v, input int k);
    return v[8*(k-1) +: 8];
  endfunction

  // starting just after talk rises; ends at first negedge with inhibit low
  task automatic measure_inhibit(output int width);
    width = 0;
    @(negedge clk);
    while (inhibit && width < 100) begin
      chk(!valid, "R1", valid, 0);
      width++;
      @(negedge clk);
    end
  endtask

  task automatic recv(input logic [39:0] exp, input string req);
    ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      chk(valid, req, valid, 1);
      chk(data == port_byte(exp, 5 - i), "R4", data, port_byte(exp, 5 - i));
      chk(last == (i == 4), "R5", last, (i == 4));
      @(negedge clk);
    end
    ready = 1'b0;
    chk(!valid, "R9", valid, 0);
  endtask

  task automatic t_reset();
    chk(!inhibit && !valid, "R1", {inhibit, valid}, 0);
  endtask

  task automatic t_basic();
    int w;
    logic [39:0] p2;
    p2 = 40'h55_44_33_22_11;
    ports = 40'hAA_BB_CC_DD_EE;
    @(negedge clk); talk_en = 1'b1;
    @(negedge clk);
    chk(inhibit, "R1", inhibit, 1);
    ports = p2;                         // change inside window
    w = 1;
    @(negedge clk);
    while (inhibit && w < 100) begin w++; @(negedge clk); end
    chk(w == INH, "R2", w, INH);
    ports = 40'hDE_AD_BE_EF_00;         // change after capture
    recv(p2, "R3");
    chk(inhibit, "R6", inhibit, 1);
    talk_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_stream();
    int w;
    logic [39:0] q;
    q = 40'h0F_1E_2D_3C_4B;
    ports = q;
    pulses = 0;
    @(negedge clk); talk_en = 1'b1;
    measure_inhibit(w);
    chk(w == INH, "R2", w, INH);
    for (int f = 0; f < 3; f++) begin
      recv(q, "R6");
      chk(inhibit, "R6", inhibit, 1);
      q = q + 40'h01_01_01_01_01;
      ports = q;
      while (inhibit) @(negedge clk);
    end
    talk_en = 1'b0;
    @(negedge clk);
    chk(pulses == 4, "R6", pulses, 4);
  endtask

  task automatic t_stall();
    int w;
    logic [7:0] held;
    ports = 40'h91_82_73_64_A5;
    @(negedge clk); talk_en = 1'b1;
    measure_inhibit(w);
    held = data;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(valid && data == held && !last, "R8", data, held);
    end
    recv(40'h91_82_73_64_A5, "R8");
    talk_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_abort();
    int w;
    ports = 40'h12_34_56_78_9A;
    @(negedge clk); talk_en = 1'b1;
    measure_inhibit(w);
    ready = 1'b1;
    @(negedge clk); @(negedge clk);
    ready = 1'b0;
    chk(data == 8'h56, "R4", data, 8'h56);
    talk_en = 1'b0;
    @(negedge clk);
    chk(!inhibit && !valid, "R7", {inhibit, valid}, 0);
    @(negedge clk); talk_en = 1'b1;
    measure_inhibit(w);
    chk(w == INH, "R7", w, INH);
    recv(40'h12_34_56_78_9A, "R7");
    talk_en = 1'b0;
    @(negedge clk);
    chk(!inhibit && !valid, "R7", {inhibit, valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    fork
      begin
        t_basic();
        t_stream();
        t_stall();
        t_abort();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule